// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer that sits beside a local interrupt controller. Software programs four registers: a start value, a live counter that can only be read, a prescaler code, and a packed 32-bit vector-table entry. Writing the start value loads the counter and starts it. Each enabled tick advances a prescaler. When the prescaler wraps, the counter drops by one.

When the counter goes from 1 to 0, the entry decides what happens. Its mask bit decides whether a request goes out. Its periodic bit decides whether the counter reloads from the stored start value or stops at zero. The request is a one-cycle pulse that carries the entry's vector, delivery mode and trigger mode. The interrupt controller next to the timer decodes those fields.

Register select codes: 0 = start value, 1 = live counter, 2 = prescaler code, 3 = vector-table entry. Reads are combinational on the selected address. Writes take effect at the clock edge.

Top module: `local_timer`

## Requirements
- R1: After reset the start value, the live counter and the prescaler code read 0, the entry reads 0x0001_0000 (only the mask bit set), and no request is raised.
- R2: A write to address 0 stores the start value and loads the live counter with it on the same edge. Writing 0 leaves the counter at 0, which is stopped, so no request follows.
- R3: With prescaler code c (bits 2:0 of address 2), a running counter drops by one after each 2^c enabled ticks. Cycles with tickEn low do not count. A write to address 2 restarts the prescaler phase.
- R4: When the counter expires with entry bit 16 (mask) clear, irqValid is high for the single cycle after that tick's edge. It carries the vector (entry bits 7:0), the delivery mode (bits 10:8) and the trigger mode (bit 15).
- R5: When entry bit 16 is set at expiry, no request is raised, but the reload or stop of R6 and R7 still happens.
- R6: With entry bit 17 (periodic) set, expiry reloads the counter from the stored start value and counting carries on.
- R7: With entry bit 17 clear, the counter stays at 0 after expiry and raises no further requests until the start value is written again.
- R8: Writes to address 1 are ignored. The entry keeps and returns only bits 7:0, 10:8, 13, 15, 16 and 17, so a write of all ones reads back 0x0003_A7FF. Address 2 keeps and returns bits 2:0 only.
- R9: Rewriting the entry while the counter runs changes neither the counter value nor the prescaler phase.
- R10: A start-value write while the counter runs restarts the count from the new value and clears the prescaler phase. It takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer tick enable for this cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector of the request |
| irqMode | output | 3 | Delivery mode of the request |
| irqLevel | output | 1 | Trigger mode of the request (1 = level) |

## Verification
The bench builds the timer with a 16-bit counter and a 3-bit prescaler code. The narrow counter exercises the zero-extension on readback. The full prescaler range stays in reach, including the divide-by-128 setting, which the bench runs to expiry. Small start values keep expiries frequent. Periodic runs with a start value of 1 make requests land on back-to-back cycles. Random writes often hit the same cycle as a tick, which exercises the priority between a start-value write and a counter step.

// File: rtl/local_timer_pkg.sv
`timescale 1ns/1ps
package local_timer_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ADDR_START = 2'd0,
    ADDR_LIVE  = 2'd1,
    ADDR_DIV   = 2'd2,
    ADDR_ENTRY = 2'd3
  } regSel_e;

  // Fields of the vector-table entry kept by the timer
  typedef struct packed {
    logic       periodic;  // bit 17
    logic       mask;      // bit 16
    logic       trigger;   // bit 15
    logic       polarity;  // bit 13
    logic [2:0] mode;      // bits 10:8
    logic [7:0] vector;    // bits 7:0
  } entry_t;

  localparam entry_t ENTRY_RESET = '{periodic: 1'b0, mask: 1'b1, trigger: 1'b0,
                                     polarity: 1'b0, mode: 3'd0, vector: 8'd0};

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStart;
    logic wrDiv;
    logic wrEntry;
    logic step;
    logic reload;
    logic fire;
    logic preClear;
    logic preAdvance;
  } strobe_t;

  function automatic logic [REG_W-1:0] packEntry(input entry_t e);
    logic [REG_W-1:0] w;
    w        = '0;
    w[7:0]   = e.vector;
    w[10:8]  = e.mode;
    w[13]    = e.polarity;
    w[15]    = e.trigger;
    w[16]    = e.mask;
    w[17]    = e.periodic;
    return w;
  endfunction

  function automatic entry_t unpackEntry(input logic [REG_W-1:0] w);
    entry_t e;
    e.vector   = w[7:0];
    e.mode     = w[10:8];
    e.polarity = w[13];
    e.trigger  = w[15];
    e.mask     = w[16];
    e.periodic = w[17];
    return e;
  endfunction

endpackage

// File: rtl/timer_ctrl.sv
`timescale 1ns/1ps
module timer_ctrl
  import local_timer_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       tickEn,
  input  logic       curIsZero,
  input  logic       curIsOne,
  input  logic       preHit,
  input  logic       entryMask,
  input  logic       entryPeriodic,
  output strobe_t    st
);

  regSel_e sel;
  logic    running;
  logic    expire;

  always_comb begin
    sel     = regSel_e'(regAddr);
    running = !curIsZero;

    st.wrStart = regWrEn && (sel == ADDR_START);
    st.wrDiv   = regWrEn && (sel == ADDR_DIV);
    st.wrEntry = regWrEn && (sel == ADDR_ENTRY);

    // A start-value write outranks a counter step in the same cycle
    st.step = tickEn && running && preHit && !st.wrStart;
    expire  = st.step && curIsOne;

    st.reload = expire && entryPeriodic;
    st.fire   = expire && !entryMask;

    st.preClear   = st.wrStart || st.wrDiv || st.step;
    st.preAdvance = tickEn && running && !st.preClear;
  end

endmodule

// File: rtl/timer_datapath.sv
`timescale 1ns/1ps
module timer_datapath
  import local_timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [REG_W-1:0]   wrData,
  input  logic [1:0]         rdAddr,
  output logic [REG_W-1:0]   rdData,
  output logic               curIsZero,
  output logic               curIsOne,
  output logic               preHit,
  output entry_t             entry,
  output logic [COUNT_W-1:0] curCount,
  output logic [COUNT_W-1:0] startCount,
  output logic               irqValid,
  output logic [7:0]         irqVector,
  output logic [2:0]         irqMode,
  output logic               irqLevel
);

  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] divCode;
  logic [PRE_W-1:0] preCount;
  logic [PRE_W-1:0] preLimit;
  logic [REG_W-1:0] curExt;
  logic [REG_W-1:0] startExt;

  // Prescaler terminal value: 2^code - 1
  always_comb begin
    preLimit = PRE_W'((32'd1 << divCode) - 32'd1);
    preHit   = (preCount == preLimit);
  end

  assign curIsZero = (curCount == '0);
  assign curIsOne  = (curCount == COUNT_W'(1));

  // Zero-extension of the counter registers onto the read bus
  generate
    if (COUNT_W < REG_W) begin : g_pad
      assign curExt   = {{(REG_W-COUNT_W){1'b0}}, curCount};
      assign startExt = {{(REG_W-COUNT_W){1'b0}}, startCount};
    end else begin : g_full
      assign curExt   = curCount[REG_W-1:0];
      assign startExt = startCount[REG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCount <= '0;
    end else if (st.wrStart) begin
      startCount <= wrData[COUNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCount <= '0;
    end else if (st.wrStart) begin
      curCount <= wrData[COUNT_W-1:0];
    end else if (st.reload) begin
      curCount <= startCount;
    end else if (st.step) begin
      curCount <= curCount - COUNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCount <= '0;
    end else if (st.preClear) begin
      preCount <= '0;
    end else if (st.preAdvance) begin
      preCount <= preCount + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCode <= '0;
    end else if (st.wrDiv) begin
      divCode <= wrData[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entry <= ENTRY_RESET;
    end else if (st.wrEntry) begin
      entry <= unpackEntry(wrData);
    end
  end

  // Request pulse, registered from the entry in force at expiry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
      irqMode   <= '0;
      irqLevel  <= 1'b0;
    end else begin
      irqValid <= st.fire;
      if (st.fire) begin
        irqVector <= entry.vector;
        irqMode   <= entry.mode;
        irqLevel  <= entry.trigger;
      end
    end
  end

  always_comb begin
    unique case (regSel_e'(rdAddr))
      ADDR_START: rdData = startExt;
      ADDR_LIVE:  rdData = curExt;
      ADDR_DIV:   rdData = {{(REG_W-DIV_W){1'b0}}, divCode};
      ADDR_ENTRY: rdData = packEntry(entry);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/local_timer.sv
`timescale 1ns/1ps
module local_timer
  import local_timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int DIV_W   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irqValid,
  output logic [7:0]  irqVector,
  output logic [2:0]  irqMode,
  output logic        irqLevel
);

  strobe_t            st;
  entry_t             entry;
  logic               curIsZero;
  logic               curIsOne;
  logic               preHit;
  logic [COUNT_W-1:0] curCount;
  logic [COUNT_W-1:0] startCount;
  logic               entryMask;
  logic               entryPeriodic;

  assign entryMask     = entry.mask;
  assign entryPeriodic = entry.periodic;

  timer_ctrl u_ctrl (
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .tickEn       (tickEn),
    .curIsZero    (curIsZero),
    .curIsOne     (curIsOne),
    .preHit       (preHit),
    .entryMask    (entryMask),
    .entryPeriodic(entryPeriodic),
    .st           (st)
  );

  timer_datapath #(.COUNT_W(COUNT_W), .DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .rdData    (regRdData),
    .curIsZero (curIsZero),
    .curIsOne  (curIsOne),
    .preHit    (preHit),
    .entry     (entry),
    .curCount  (curCount),
    .startCount(startCount),
    .irqValid  (irqValid),
    .irqVector (irqVector),
    .irqMode   (irqMode),
    .irqLevel  (irqLevel)
  );

endmodule

// File: rtl/local_timer_checker.sv
`timescale 1ns/1ps
module local_timer_checker #(
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               tickEn,
  input logic               regWrEn,
  input logic [1:0]         regAddr,
  input logic [31:0]        regWrData,
  input logic               irqValid,
  input logic [COUNT_W-1:0] curCount,
  input logic [COUNT_W-1:0] startCount,
  input logic               entryMask,
  input logic               entryPeriodic
);

  logic startWr;
  assign startWr = regWrEn && (regAddr == 2'd0);

  assert_zero_stops_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && regWrData[COUNT_W-1:0] == '0) |=> (curCount == '0 && !irqValid));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !startWr) |=> $stable(curCount));

  assert_fire_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ($past(curCount) == COUNT_W'(1) && $past(tickEn)));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(entryMask));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !startWr && curCount == COUNT_W'(1) && entryPeriodic && $past(rstN))
      |=> (curCount == startCount || curCount == COUNT_W'(1)));

  assert_oneshot_stays_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == '0 && !startWr) |=> (curCount == '0 && !irqValid));

  assert_entry_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && !tickEn) |=> $stable(curCount));

endmodule

bind local_timer local_timer_checker #(.COUNT_W(COUNT_W)) chk (
  .clk          (clk),
  .rstN         (rstN),
  .tickEn       (tickEn),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .regWrData    (regWrData),
  .irqValid     (irqValid),
  .curCount     (curCount),
  .startCount   (startCount),
  .entryMask    (entryMask),
  .entryPeriodic(entryPeriodic)
);

// File: tb/local_timer_test.sv
`timescale 1ns/1ps
module local_timer_test;

  localparam int CW = 16;
  localparam int DW = 3;
  localparam logic [31:0] ENTRY_KEEP = 32'h0003_A7FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqValid;
  logic [7:0]  irqVector;
  logic [2:0]  irqMode;
  logic        irqLevel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements
  logic [CW-1:0] mStart, mCur;
  int            mPre;
  logic [2:0]    mDiv;
  logic [31:0]   mEntry;
  logic          mIrq;
  logic [7:0]    mVec;
  logic [2:0]    mMode;
  logic          mLvl;

  always #2.5 clk = ~clk;

  local_timer #(.COUNT_W(CW), .DIV_W(DW)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqValid(irqValid), .irqVector(irqVector), .irqMode(irqMode),
    .irqLevel(irqLevel)
  );

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0:    return {16'd0, mStart};
      2'd1:    return {16'd0, mCur};
      2'd2:    return {29'd0, mDiv};
      default: return mEntry;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mStart = '0; mCur = '0; mPre = 0; mDiv = '0;
    mEntry = 32'h0001_0000; mIrq = 1'b0; mVec = '0; mMode = '0; mLvl = 1'b0;
  endtask

  task automatic modelStep(input logic we, input logic [1:0] a,
                           input logic [31:0] d, input logic tk);
    logic wrS, wrD, wrE, hit, stp, expd;
    wrS  = we && a == 2'd0;
    wrD  = we && a == 2'd2;
    wrE  = we && a == 2'd3;
    hit  = (mPre == (1 << mDiv) - 1);
    stp  = tk && mCur != 0 && hit && !wrS;
    expd = stp && mCur == 1;
    mIrq = expd && !mEntry[16];
    if (mIrq) begin
      mVec = mEntry[7:0]; mMode = mEntry[10:8]; mLvl = mEntry[15];
    end
    if (wrS || wrD || stp) mPre = 0;
    else if (tk && mCur != 0) mPre = mPre + 1;
    if (wrS) begin
      mStart = d[CW-1:0]; mCur = d[CW-1:0];
    end else if (expd) begin
      mCur = mEntry[17] ? mStart : '0;
    end else if (stp) begin
      mCur = mCur - 1'b1;
    end
    if (wrD) mDiv = d[2:0];
    if (wrE) mEntry = d & ENTRY_KEEP;
  endtask

  // One cycle: drive at negedge, check read, clock, check request at next negedge
  task automatic cyc(input string tag, input logic we, input logic [1:0] a,
                     input logic [31:0] d, input logic tk);
    regWrEn = we; regAddr = a; regWrData = d; tickEn = tk;
    #1;
    check(tag, "read", regRdData, modelRead(a));
    @(posedge clk);
    modelStep(we, a, d, tk);
    @(negedge clk);
    check(tag, "irqValid", {31'd0, irqValid}, {31'd0, mIrq});
    if (mIrq) begin
      check(tag, "irqVector", {24'd0, irqVector}, {24'd0, mVec});
      check(tag, "irqMode", {29'd0, irqMode}, {29'd0, mMode});
      check(tag, "irqLevel", {31'd0, irqLevel}, {31'd0, mLvl});
    end
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
    cyc(tag, 1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 2'd1, '0, 1'b1);
  endtask

  task automatic expectRead(input string tag, input logic [1:0] a, input logic [31:0] lit);
    regWrEn = 1'b0; tickEn = 1'b0; regAddr = a;
    #1;
    check(tag, "literal read", regRdData, lit);
  endtask

  task automatic expectIrq(input string tag, input logic v, input logic [7:0] vec);
    check(tag, "literal irqValid", {31'd0, irqValid}, {31'd0, v});
    if (v) check(tag, "literal irqVector", {24'd0, irqVector}, {24'd0, vec});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    expectRead("R1", 2'd0, 32'h0);
    expectRead("R1", 2'd1, 32'h0);
    expectRead("R1", 2'd2, 32'h0);
    expectRead("R1", 2'd3, 32'h0001_0000);
    expectIrq("R1", 1'b0, 8'h0);
    @(negedge clk);

    // R2: start value loads the counter; zero stops it
    wr("R2", 2'd0, 32'd9);
    expectRead("R2", 2'd1, 32'd9);
    expectRead("R2", 2'd0, 32'd9);
    @(negedge clk);
    ticks("R2", 2);
    expectRead("R2", 2'd1, 32'd7);
    @(negedge clk);
    wr("R2", 2'd0, 32'd0);
    ticks("R2", 5);
    expectRead("R2", 2'd1, 32'd0);
    expectIrq("R2", 1'b0, 8'h0);
    @(negedge clk);

    // R4: unmasked one-shot expiry carries the entry fields
    wr("R4", 2'd3, 32'h0000_C45A); // vector 5A, mode 4, level, polarity 0
    wr("R4", 2'd0, 32'd3);
    ticks("R4", 2);
    expectIrq("R4", 1'b0, 8'h0);
    ticks("R4", 1);
    expectIrq("R4", 1'b1, 8'h5A);
    check("R4", "literal irqMode", {29'd0, irqMode}, 32'd4);
    check("R4", "literal irqLevel", {31'd0, irqLevel}, 32'd1);

    // R7: one-shot stays at zero
    ticks("R7", 6);
    expectRead("R7", 2'd1, 32'd0);
    expectIrq("R7", 1'b0, 8'h0);
    @(negedge clk);

    // R5: masked periodic reloads silently
    wr("R5", 2'd3, 32'h0003_0011);
    wr("R5", 2'd0, 32'd2);
    ticks("R5", 2);
    expectIrq("R5", 1'b0, 8'h0);
    expectRead("R5", 2'd1, 32'd2);
    @(negedge clk);

    // R6: periodic unmasked, start value 1 gives back-to-back requests
    wr("R6", 2'd3, 32'h0002_0021);
    wr("R6", 2'd0, 32'd1);
    ticks("R6", 1);
    expectIrq("R6", 1'b1, 8'h21);
    @(negedge clk);
    ticks("R6", 1);
    expectIrq("R6", 1'b1, 8'h21);
    expectRead("R6", 2'd1, 32'd1);
    @(negedge clk);

    // R3: prescaler divide by 4, with idle gaps
    wr("R3", 2'd3, 32'h0001_0000);
    wr("R3", 2'd2, 32'd2);
    wr("R3", 2'd0, 32'd3);
    ticks("R3", 3);
    cyc("R3", 1'b0, 2'd1, '0, 1'b0);
    expectRead("R3", 2'd1, 32'd3);
    @(negedge clk);
    ticks("R3", 1);
    expectRead("R3", 2'd1, 32'd2);
    @(negedge clk);
    // R3: divide by 128 to expiry
    wr("R3", 2'd3, 32'h0000_0077);
    wr("R3", 2'd2, 32'd7);
    wr("R3", 2'd0, 32'd1);
    ticks("R3", 127);
    expectIrq("R3", 1'b0, 8'h0);
    ticks("R3", 1);
    expectIrq("R3", 1'b1, 8'h77);
    @(negedge clk);

    // R8: ignored and trimmed writes
    wr("R8", 2'd2, 32'd0);
    wr("R8", 2'd0, 32'd40);
    wr("R8", 2'd1, 32'd5);
    expectRead("R8", 2'd1, 32'd40);
    @(negedge clk);
    wr("R8", 2'd3, 32'hFFFF_FFFF);
    expectRead("R8", 2'd3, 32'h0003_A7FF);
    @(negedge clk);
    wr("R8", 2'd2, 32'hFFFF_FFFF);
    expectRead("R8", 2'd2, 32'd7);
    @(negedge clk);

    // R9: entry rewrite mid-count keeps count and prescaler phase
    wr("R9", 2'd2, 32'd1);
    wr("R9", 2'd3, 32'h0001_0000);
    wr("R9", 2'd0, 32'd10);
    ticks("R9", 1);
    cyc("R9", 1'b1, 2'd3, 32'h0001_0042, 1'b1);
    expectRead("R9", 2'd1, 32'd9);
    @(negedge clk);
    wr("R9", 2'd3, 32'h0001_0043);
    expectRead("R9", 2'd1, 32'd9);
    @(negedge clk);

    // R10: start write mid-count restarts and clears the prescaler
    ticks("R10", 1);
    cyc("R10", 1'b1, 2'd0, 32'd4, 1'b1);
    expectRead("R10", 2'd1, 32'd4);
    @(negedge clk);
    ticks("R10", 1);
    expectRead("R10", 2'd1, 32'd4);
    @(negedge clk);
    ticks("R10", 1);
    expectRead("R10", 2'd1, 32'd3);
    @(negedge clk);

    // Random mix against the reference state (R3, R6, R10 interplay)
    for (int n = 0; n < 4000; n++) begin
      logic        we;
      logic [1:0]  a;
      logic [31:0] d;
      logic        tk;
      we = ($urandom % 12) == 0;
      a  = 2'($urandom % 4);
      tk = ($urandom % 4) != 0;
      case (a)
        2'd0:    d = $urandom % 12;
        2'd2:    d = $urandom % 3;
        default: d = $urandom;
      endcase
      cyc("R6", we, a, d, tk);
    end

    finishRun();
  end

endmodule